// File: doc/BRIEF.md
# Gated Synchronous Frequency Counter

This block measures how often an external digital signal toggles. It counts the rising edges of that signal during a gate window whose length is a fixed number of system clock cycles. At the end of every window it hands the result to an output register. The signal under test is never used as a clock. It is brought into the system clock domain through a three-stage shift register, and a rising edge is recognised there as a one-cycle event. Every register in the block runs on the one system clock and uses a synchronous reset.

Two window lengths can be selected. The short window is the plain measurement interval, for example 4000 cycles, which is 100 µs at 40 MHz. The long window is stretched by the factor 1.023, for example 4092 cycles. With the long window the captured count already carries that scale factor, so no multiplier is needed. Each capture is announced by a one-cycle strobe. A count that exceeds the counter range is clamped, and a flag is raised with it.

Top module: `freq_gate_counter`

## Requirements
- R1: The measured input passes through a 3-stage synchronizer. The input must hold each level for at least two clock cycles. Under that condition, each low-to-high transition of the input is counted exactly once.
- R2: With the select input `gate_long` at 0, successive assertions of `valid_out` lie exactly SHORT_LEN clock cycles apart.
- R3: With `gate_long` at 1, successive assertions of `valid_out` lie exactly LONG_LEN clock cycles apart.
- R4: A change of `gate_long` alters only the window that starts after the current window ends. The current window keeps its length.
- R5: `valid_out` is high for exactly one cycle per capture. `count_out` and `ovf_out` keep their captured values until the next capture.
- R6: While reset is held and after it is released, `count_out` is 0 and `ovf_out` and `valid_out` are 0. The first window after reset is a short window, and its capture appears SHORT_LEN cycles after reset is released.
- R7: The edge count restarts at each window boundary. A capture reports only the edges that were detected inside that window, and a window with no edges reports 0.
- R8: An edge detected in the last cycle of a window is counted as the first edge of the next window. It is neither lost nor added to the closing window.
- R9: The edge count saturates at 2**CNT_W-1. When more edges occur than that, the capture reports 2**CNT_W-1 with `ovf_out` at 1. The next window starts again with `ovf_out` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| meas_in | input | 1 | Signal under measurement, asynchronous to clk |
| gate_long | input | 1 | Window select: 0 = short window, 1 = long (×1.023) window |
| count_out | output | CNT_W | Edge count captured from the last complete window |
| ovf_out | output | 1 | Set when the captured window held more edges than the counter can represent |
| valid_out | output | 1 | One-cycle strobe, high on each capture |

## Verification
The bench builds the block with SHORT_LEN = 80, LONG_LEN = 88, GATE_W = 7 and CNT_W = 4. With these values a whole window takes fewer than a hundred cycles. This makes it practical to measure the spacing between strobes cycle by cycle for both window settings and across a change of the select input. The 4-bit counter lets a single window of 18 pulses drive the count past its ceiling of 15. The short windows also make it practical to place an edge exactly on the last cycle of a window and follow how the count splits between the two windows.

// File: rtl/freqc_pkg.sv
package freqc_pkg;
   localparam int unsigned DEF_SHORT_LEN = 4000;
   localparam int unsigned DEF_LONG_LEN  = 4092;
   localparam int unsigned DEF_GATE_W    = 12;
   localparam int unsigned DEF_CNT_W     = 12;
   localparam int unsigned DEF_STAGES    = 3;

   typedef enum logic {
      GATE_SHORT = 1'b0,
      GATE_LONG  = 1'b1
   } gate_sel_e;
endpackage

// File: rtl/freqc_edge_sync.sv
module freqc_edge_sync #(
   parameter int unsigned STAGES = freqc_pkg::DEF_STAGES
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic rise
);
   localparam int unsigned NEWER = STAGES - 2;
   localparam int unsigned OLDER = STAGES - 1;

   logic [STAGES-1:0] shreg;

   generate
      if (STAGES < 3) begin : g_bad_stages
         $error("freqc_edge_sync: STAGES must be at least 3");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) shreg[0] <= 1'b0;
               else     shreg[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) shreg[i] <= 1'b0;
               else     shreg[i] <= shreg[i-1];
            end
         end
      end
   endgenerate

   assign rise = shreg[NEWER] & ~shreg[OLDER];
endmodule

// File: rtl/freqc_gate_timer.sv
module freqc_gate_timer #(
   parameter int unsigned GATE_W    = freqc_pkg::DEF_GATE_W,
   parameter int unsigned SHORT_LEN = freqc_pkg::DEF_SHORT_LEN,
   parameter int unsigned LONG_LEN  = freqc_pkg::DEF_LONG_LEN
) (
   input  logic clk,
   input  logic rst,
   input  logic gate_long,
   output logic term,
   output logic sel_q
);
   import freqc_pkg::*;

   localparam logic [GATE_W-1:0] SHORT_LAST = GATE_W'(SHORT_LEN - 1);
   localparam logic [GATE_W-1:0] LONG_LAST  = GATE_W'(LONG_LEN - 1);

   generate
      if (SHORT_LEN < 2 || LONG_LEN < 2) begin : g_bad_len
         $error("freqc_gate_timer: window lengths must be at least 2");
      end
      if (LONG_LEN > (1 << GATE_W) || SHORT_LEN > (1 << GATE_W)) begin : g_bad_width
         $error("freqc_gate_timer: GATE_W too narrow for window length");
      end
   endgenerate

   logic [GATE_W-1:0] tmr;
   logic [GATE_W-1:0] last;

   always_comb begin
      last = (gate_sel_e'(sel_q) == GATE_LONG) ? LONG_LAST : SHORT_LAST;
      term = (tmr == last);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tmr   <= '0;
         sel_q <= GATE_SHORT;
      end else if (term) begin
         tmr   <= '0;
         sel_q <= gate_long;
      end else begin
         tmr   <= tmr + 1'b1;
      end
   end
endmodule

// File: rtl/freqc_edge_counter.sv
module freqc_edge_counter #(
   parameter int unsigned CNT_W = freqc_pkg::DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rise,
   input  logic             term,
   output logic [CNT_W-1:0] live_cnt,
   output logic [CNT_W-1:0] count_out,
   output logic             ovf_out,
   output logic             valid_out
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("freqc_edge_counter: CNT_W must be at least 2");
      end
   endgenerate

   logic ovf_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         live_cnt  <= '0;
         ovf_q     <= 1'b0;
         count_out <= '0;
         ovf_out   <= 1'b0;
         valid_out <= 1'b0;
      end else begin
         valid_out <= term;
         if (term) begin
            count_out <= live_cnt;
            ovf_out   <= ovf_q;
            live_cnt  <= rise ? CNT_W'(1) : '0;
            ovf_q     <= 1'b0;
         end else if (rise) begin
            if (live_cnt == CNT_MAX) ovf_q    <= 1'b1;
            else                     live_cnt <= live_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/freq_gate_counter.sv
module freq_gate_counter #(
   parameter int unsigned SHORT_LEN = freqc_pkg::DEF_SHORT_LEN,
   parameter int unsigned LONG_LEN  = freqc_pkg::DEF_LONG_LEN,
   parameter int unsigned GATE_W    = freqc_pkg::DEF_GATE_W,
   parameter int unsigned CNT_W     = freqc_pkg::DEF_CNT_W,
   parameter int unsigned STAGES    = freqc_pkg::DEF_STAGES
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             meas_in,
   input  logic             gate_long,
   output logic [CNT_W-1:0] count_out,
   output logic             ovf_out,
   output logic             valid_out
);
   logic             rise;
   logic             term;
   logic             sel_q;
   logic [CNT_W-1:0] live_cnt;

   freqc_edge_sync #(.STAGES(STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (meas_in),
      .rise (rise)
   );

   freqc_gate_timer #(
      .GATE_W    (GATE_W),
      .SHORT_LEN (SHORT_LEN),
      .LONG_LEN  (LONG_LEN)
   ) u_timer (
      .clk       (clk),
      .rst       (rst),
      .gate_long (gate_long),
      .term      (term),
      .sel_q     (sel_q)
   );

   freqc_edge_counter #(.CNT_W(CNT_W)) u_count (
      .clk       (clk),
      .rst       (rst),
      .rise      (rise),
      .term      (term),
      .live_cnt  (live_cnt),
      .count_out (count_out),
      .ovf_out   (ovf_out),
      .valid_out (valid_out)
   );
endmodule

// File: rtl/freqc_checker.sv
module freqc_checker #(
   parameter int unsigned SHORT_LEN = 4000,
   parameter int unsigned LONG_LEN  = 4092,
   parameter int unsigned CNT_W     = 12
) (
   input logic             clk,
   input logic             rst,
   input logic             gate_long,
   input logic             rise,
   input logic             term,
   input logic             sel_q,
   input logic [CNT_W-1:0] live_cnt,
   input logic [CNT_W-1:0] count_out,
   input logic             ovf_out,
   input logic             valid_out
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [15:0] gap;
   logic        seen;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap  <= '0;
         seen <= 1'b0;
      end else if (valid_out) begin
         gap  <= '0;
         seen <= 1'b1;
      end else if (gap != 16'hFFFF) begin
         gap  <= gap + 1'b1;
      end
   end

   p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
      valid_out |=> !valid_out);

   p_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !valid_out |-> ($stable(count_out) && $stable(ovf_out)));

   p_reset_r6: assert property (@(posedge clk)
      rst |=> (count_out == '0 && !ovf_out && !valid_out));

   p_first_window_r6: assert property (@(posedge clk) disable iff (rst)
      (valid_out && !seen) |-> (gap == 16'(SHORT_LEN)));

   p_period_r2: assert property (@(posedge clk) disable iff (rst)
      (valid_out && seen) |-> (gap == 16'(SHORT_LEN - 1) || gap == 16'(LONG_LEN - 1)));

   p_sel_stable_r4: assert property (@(posedge clk) disable iff (rst)
      !term |=> $stable(sel_q));

   p_sel_load_r4: assert property (@(posedge clk) disable iff (rst)
      term |=> (sel_q == $past(gate_long)));

   p_boundary_r8: assert property (@(posedge clk) disable iff (rst)
      (term && rise) |=> (live_cnt == CNT_W'(1)));

   p_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
      (rise && !term && live_cnt == CNT_MAX) |=> (live_cnt == CNT_MAX));

   p_ovf_sat_r9: assert property (@(posedge clk) disable iff (rst)
      ovf_out |-> (count_out == CNT_MAX));
endmodule

bind freq_gate_counter freqc_checker #(
   .SHORT_LEN (SHORT_LEN),
   .LONG_LEN  (LONG_LEN),
   .CNT_W     (CNT_W)
) u_freqc_checker (
   .clk       (clk),
   .rst       (rst),
   .gate_long (gate_long),
   .rise      (rise),
   .term      (term),
   .sel_q     (sel_q),
   .live_cnt  (live_cnt),
   .count_out (count_out),
   .ovf_out   (ovf_out),
   .valid_out (valid_out)
);

// File: tb/test_freq_gate_counter.sv
`timescale 1ns/1ps
module test_freq_gate_counter;
   localparam int SHORT_LEN = 80;
   localparam int LONG_LEN  = 88;
   localparam int CNT_W     = 4;
   localparam int CNT_MAX   = (1 << CNT_W) - 1;

   logic             clk = 1'b0;
   logic             rst;
   logic             meas_in;
   logic             gate_long;
   logic [CNT_W-1:0] count_out;
   logic             ovf_out;
   logic             valid_out;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   freq_gate_counter #(
      .SHORT_LEN (SHORT_LEN),
      .LONG_LEN  (LONG_LEN),
      .GATE_W    (7),
      .CNT_W     (CNT_W),
      .STAGES    (3)
   ) i_freq_gate_counter (
      .clk       (clk),
      .rst       (rst),
      .meas_in   (meas_in),
      .gate_long (gate_long),
      .count_out (count_out),
      .ovf_out   (ovf_out),
      .valid_out (valid_out)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_valid(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!valid_out && n < 1000);
   endtask

   task automatic send_pulses(input int n);
      repeat (2) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         meas_in = 1'b1;
         repeat (2) @(negedge clk);
         meas_in = 1'b0;
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic t_reset;
      int n;
      rst = 1'b1; meas_in = 1'b0; gate_long = 1'b0;
      repeat (3) @(negedge clk);
      check("R6 reset count", int'(count_out), 0);
      check("R6 reset valid", int'(valid_out), 0);
      check("R6 reset ovf", int'(ovf_out), 0);
      rst = 1'b0;
      wait_valid(n);
      check("R6 first window length", n, SHORT_LEN);
      check("R6 first capture empty", int'(count_out), 0);
   endtask

   task automatic t_counts;
      int n;
      send_pulses(5);
      wait_valid(n);
      check("R1 five edges", int'(count_out), 5);
      check("R2 short spacing", n + 22, SHORT_LEN);
      send_pulses(9);
      wait_valid(n);
      check("R7 nine edges", int'(count_out), 9);
      wait_valid(n);
      check("R7 empty window", int'(count_out), 0);
      check("R2 idle spacing", n, SHORT_LEN);
   endtask

   task automatic t_hold;
      int n;
      send_pulses(3);
      wait_valid(n);
      @(negedge clk);
      check("R5 strobe one cycle", int'(valid_out), 0);
      send_pulses(6);
      check("R5 count held mid-window", int'(count_out), 3);
      wait_valid(n);
      check("R5 next capture", int'(count_out), 6);
   endtask

   task automatic t_select;
      int n;
      repeat (10) @(negedge clk);
      gate_long = 1'b1;
      wait_valid(n);
      check("R4 current window unchanged", n + 10, SHORT_LEN);
      send_pulses(7);
      wait_valid(n);
      check("R3 long spacing", n + 30, LONG_LEN);
      check("R3 long window count", int'(count_out), 7);
      repeat (5) @(negedge clk);
      gate_long = 1'b0;
      wait_valid(n);
      check("R4 long kept until boundary", n + 5, LONG_LEN);
      wait_valid(n);
      check("R2 back to short", n, SHORT_LEN);
   endtask

   task automatic t_boundary;
      int n;
      send_pulses(3);
      repeat (SHORT_LEN - 3 - 14) @(negedge clk);
      meas_in = 1'b1;
      wait_valid(n);
      check("R8 closing window excludes edge", int'(count_out), 3);
      repeat (4) @(negedge clk);
      meas_in = 1'b0;
      wait_valid(n);
      check("R8 edge moves to new window", int'(count_out), 1);
   endtask

   task automatic t_saturate;
      int n;
      send_pulses(18);
      wait_valid(n);
      check("R9 saturated count", int'(count_out), CNT_MAX);
      check("R9 overflow flag", int'(ovf_out), 1);
      send_pulses(2);
      wait_valid(n);
      check("R9 count after overflow", int'(count_out), 2);
      check("R9 overflow cleared", int'(ovf_out), 0);
   endtask

   initial begin
      t_reset();
      t_counts();
      t_hold();
      t_select();
      t_boundary();
      t_saturate();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule